// File: doc/BRIEF.md
# Configurable UART frame receiver

This block recovers characters from one asynchronous serial line. Its system clock runs at a fixed whole multiple of the baud rate, and that multiple is the parameter `CLKS_PER_BIT`. The line idles high. A falling edge starts a frame. The time of that edge sets every later sample point, and each slot is sampled half a bit period after the point where it starts.

The frame format is set at run time. The data field is 5 to 9 bits long and is received either least significant bit first or most significant bit first. An optional parity slot may follow the data, and one stop bit ends the frame. The line can be complemented before the block uses it. The format inputs are captured at the start edge, so changing them during a frame has no effect until the next frame.

Each frame produces a 9-bit word and a strobe one clock wide. Three error flags are valid in the same cycle as the strobe. A start slot that reads high is flagged, but the block still receives the rest of that frame.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, `data_valid` and all three error flags are low. While the line stays idle, no strobe and no flag is raised.
- R2: A high-to-low transition of the line while idle starts a frame. Slot n is sampled `CLKS_PER_BIT/2 + n*CLKS_PER_BIT` clocks after the edge, where slot 0 is the start bit and slots 1 to N hold the data.
- R3: `cfg_len` gives the number of data bits directly, from 5 to 9. A value below 5 acts as 5 and a value above 9 acts as 9. Bits of `data_out` at and above the data length read 0.
- R4: With `cfg_msb_first`=0 the first data bit received is `data_out[0]`. With `cfg_msb_first`=1 the first data bit received is `data_out[N-1]`.
- R5: Parity code 1 (odd) requires the ones in the data and the parity bit together to be odd. Parity code 2 (even) requires that total to be even. When `cfg_par_check`=1, a violation raises `err_parity`.
- R6: Parity code 3 requires the parity bit to be 0. Parity code 4 requires it to be 1. When `cfg_par_check`=1, a violation raises `err_parity`.
- R7: Parity code 0, and codes 5 to 7, mean that the frame has no parity slot, so the stop bit follows the data directly. `err_parity` stays low in these modes, and it also stays low whenever `cfg_par_check`=0.
- R8: A stop bit sampled low raises `err_frame`. In every case the receiver then waits for the next start edge, and the next frame is received normally.
- R9: A start slot that samples high raises `err_start`. The rest of the frame is still received and delivered with its data.
- R10: With `cfg_invert`=1 the line is complemented before edge detection and sampling, so idle is low and the start bit is high.
- R11: `data_valid` is high for exactly one clock per frame, in the cycle after the stop-bit sample. The error flags are high only in that same cycle.
- R12: The configuration inputs are captured at the start edge. A change made during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLKS_PER_BIT` clocks per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Asynchronous serial line |
| cfg_len | input | 4 | Number of data bits, 5 to 9 |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| cfg_parity | input | 3 | 0 none, 1 odd, 2 even, 3 always-0, 4 always-1 |
| cfg_par_check | input | 1 | 1 = report parity violations |
| cfg_invert | input | 1 | 1 = complement the line |
| data_out | output | 9 | Received word, right-aligned |
| data_valid | output | 1 | One-clock strobe for each frame |
| err_start | output | 1 | Start slot sampled high |
| err_parity | output | 1 | Parity violation |
| err_frame | output | 1 | Stop bit sampled low |

## Verification
A wrong bit counter or a wrong slot decision shows up when the frame ends. The word comes out shifted or misordered, or the strobe falls in the wrong frame. A frame whose wrong stop slot happens to land on the idle line gives no sign at all. A lost sample phase shows first on the following frames, as data off by one bit or as a stop bit read low, so every frame in the bench is compared the moment its strobe appears. A state machine that never leaves a frame shows as missing strobes, which the queue that is still non-empty at the end exposes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_SPACE = 3'd3,
    PAR_MARK  = 3'd4
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [3:0] len;
    logic       msb;
    par_mode_e  par;
    logic       chk;
    logic       inv;
  } rx_cfg_t;

  // Force the requested data length into the supported range.
  function automatic logic [3:0] clamp_len(input logic [3:0] l);
    if (l < 4'd5) return 4'd5;
    if (l > 4'd9) return 4'd9;
    return l;
  endfunction

  function automatic logic has_parity(input par_mode_e m);
    return (m == PAR_ODD) || (m == PAR_EVEN) || (m == PAR_SPACE) || (m == PAR_MARK);
  endfunction

  // Put one received bit into the partial word.
  function automatic logic [8:0] shift_in(input logic [8:0] w, input logic b,
                                          input logic [3:0] len, input logic msb);
    if (msb) return {w[7:0], b};
    return (w >> 1) | (9'(b) << (len - 4'd1));
  endfunction

  // Return 1 when the parity bit breaks the rule of the chosen mode.
  function automatic logic parity_bad(input par_mode_e m, input logic pbit,
                                      input logic [8:0] w);
    case (m)
      PAR_ODD:   return ~(^w ^ pbit);
      PAR_EVEN:  return ^w ^ pbit;
      PAR_SPACE: return pbit;
      PAR_MARK:  return ~pbit;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic inv,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= din ^ inv;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b1;
      else        chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int HALF  = CLKS_PER_BIT / 2;
  localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] LIM_FULL = CNT_W'(CLKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt;
  logic             in_half;
  logic             at_lim;

  assign at_lim = (cnt == (in_half ? LIM_HALF : LIM_FULL));
  assign tick   = run && !restart && at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      in_half <= 1'b1;
    end else if (restart) begin
      cnt     <= '0;
      in_half <= 1'b1;
    end else if (run) begin
      if (at_lim) begin
        cnt     <= '0;
        in_half <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       en,
  input  logic       bit_in,
  input  logic [3:0] len,
  input  logic       msb,
  output logic [8:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (clear) word <= '0;
    else if (en)    word <= shift_in(word, bit_in, len, msb);
  end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic [3:0] cfg_len,
  input  logic       cfg_msb_first,
  input  logic [2:0] cfg_parity,
  input  logic       cfg_par_check,
  input  logic       cfg_invert,
  output logic [8:0] data_out,
  output logic       data_valid,
  output logic       err_start,
  output logic       err_parity,
  output logic       err_frame
);
  rx_state_e state;
  rx_cfg_t   cfg_q;
  logic      line, line_q;
  logic      busy, fall, bit_tick, inv_eff;
  logic      start_bad, pbit;
  logic [3:0] dcnt;
  logic [8:0] word;

  assign busy    = (state != ST_IDLE);
  assign inv_eff = busy ? cfg_q.inv : cfg_invert;
  assign fall    = !busy && line_q && !line;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .inv(inv_eff), .dout(line)
  );

  uart_rx_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_baud (
    .clk(clk), .rst_n(rst_n), .restart(fall), .run(busy), .tick(bit_tick)
  );

  uart_rx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .clear(fall),
    .en(bit_tick && (state == ST_DATA)), .bit_in(line),
    .len(cfg_q.len), .msb(cfg_q.msb), .word(word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      line_q     <= 1'b1;
      cfg_q.len  <= 4'd8;
      cfg_q.msb  <= 1'b0;
      cfg_q.par  <= PAR_NONE;
      cfg_q.chk  <= 1'b0;
      cfg_q.inv  <= 1'b0;
      start_bad  <= 1'b0;
      pbit       <= 1'b0;
      dcnt       <= '0;
      data_out   <= '0;
      data_valid <= 1'b0;
      err_start  <= 1'b0;
      err_parity <= 1'b0;
      err_frame  <= 1'b0;
    end else begin
      line_q     <= line;
      data_valid <= 1'b0;
      err_start  <= 1'b0;
      err_parity <= 1'b0;
      err_frame  <= 1'b0;
      if (fall) begin
        cfg_q.len <= clamp_len(cfg_len);
        cfg_q.msb <= cfg_msb_first;
        cfg_q.par <= par_mode_e'(cfg_parity);
        cfg_q.chk <= cfg_par_check;
        cfg_q.inv <= cfg_invert;
        state     <= ST_START;
      end else if (bit_tick) begin
        case (state)
          ST_START: begin
            start_bad <= line;
            dcnt      <= '0;
            state     <= ST_DATA;
          end
          ST_DATA: begin
            dcnt <= dcnt + 4'd1;
            if (dcnt == cfg_q.len - 4'd1)
              state <= has_parity(cfg_q.par) ? ST_PAR : ST_STOP;
          end
          ST_PAR: begin
            pbit  <= line;
            state <= ST_STOP;
          end
          ST_STOP: begin
            data_out   <= word;
            data_valid <= 1'b1;
            err_start  <= start_bad;
            err_parity <= cfg_q.chk && parity_bad(cfg_q.par, pbit, word);
            err_frame  <= !line;
            state      <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_checks.sv
module uart_rx_checks
  import uart_rx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] data_out,
  input logic       data_valid,
  input logic       err_start,
  input logic       err_parity,
  input logic       err_frame,
  input logic       bit_tick,
  input logic       busy,
  input rx_cfg_t    cfg_q
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid); // R11

  AST_FLAGS_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_start || err_parity || err_frame) |-> data_valid); // R11

  AST_UPPER_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> ((data_out >> cfg_q.len) == 9'd0)); // R3

  AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cfg_q.len >= 4'd5 && cfg_q.len <= 4'd9)); // R3

  AST_PARITY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && (!cfg_q.chk || !has_parity(cfg_q.par))) |-> !err_parity); // R7

  AST_TICK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> busy); // R2

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q)); // R12
endmodule

bind uart_frame_rx uart_rx_checks u_chk (
  .clk(clk), .rst_n(rst_n), .data_out(data_out), .data_valid(data_valid),
  .err_start(err_start), .err_parity(err_parity), .err_frame(err_frame),
  .bit_tick(bit_tick), .busy(busy), .cfg_q(cfg_q)
);

// File: tb/sim_uart_frame_rx.sv
`timescale 1ns/1ps
module sim_uart_frame_rx;
  localparam int CPB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic [3:0] cfg_len = 4'd8;
  logic       cfg_msb_first = 1'b0;
  logic [2:0] cfg_parity = 3'd0;
  logic       cfg_par_check = 1'b1;
  logic       cfg_invert = 1'b0;
  logic [8:0] data_out;
  logic       data_valid, err_start, err_parity, err_frame;

  typedef struct {
    logic [8:0] d;
    logic es, ep, ef;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit drv_inv = 1'b0;
  bit prev_valid = 1'b0;

  always #4 clk = ~clk;

  uart_frame_rx #(.CLKS_PER_BIT(CPB)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .cfg_len(cfg_len),
    .cfg_msb_first(cfg_msb_first), .cfg_parity(cfg_parity),
    .cfg_par_check(cfg_par_check), .cfg_invert(cfg_invert),
    .data_out(data_out), .data_valid(data_valid), .err_start(err_start),
    .err_parity(err_parity), .err_frame(err_frame)
  );

  task automatic hold(input bit lvl, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_in = lvl ^ drv_inv;
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Driver: queues the expected result, then drives one frame.
  task automatic send(input logic [8:0] d, input int len, input bit msb,
                      input int par, input bit chk, input bit inv,
                      input bit bad_par, input bit stop_lvl, input bit glitch,
                      input bit flip_mid, input string tag);
    exp_t e;
    int eff_len, ones;
    bit p;
    eff_len = (len < 5) ? 5 : ((len > 9) ? 9 : len);
    @(negedge clk);
    cfg_len = 4'(len); cfg_msb_first = msb; cfg_parity = 3'(par);
    cfg_par_check = chk; cfg_invert = inv; drv_inv = inv;
    rx_in = 1'b1 ^ inv;
    hold(1'b1, 2 * CPB);
    ones = 0;
    for (int i = 0; i < eff_len; i++) ones += int'(d[i]);
    case (par)
      1: p = (ones % 2 == 0);
      2: p = (ones % 2 == 1);
      3: p = 1'b0;
      4: p = 1'b1;
      default: p = 1'b0;
    endcase
    if (bad_par) p = !p;
    e.d   = d & 9'((1 << eff_len) - 1);
    e.es  = glitch;
    e.ep  = chk && bad_par && (par >= 1 && par <= 4);
    e.ef  = !stop_lvl;
    e.tag = tag;
    exp_q.push_back(e);
    if (glitch) begin
      hold(1'b0, 2);
      hold(1'b1, CPB - 2);
    end else begin
      hold(1'b0, CPB);
    end
    if (flip_mid) begin
      cfg_msb_first = !msb;
      cfg_len = (eff_len == 9) ? 4'd5 : 4'd9;
      cfg_parity = (par == 0) ? 3'd1 : 3'd0;
      cfg_par_check = !chk;
    end
    for (int i = 0; i < eff_len; i++)
      hold(msb ? d[eff_len-1-i] : d[i], CPB);
    if (par >= 1 && par <= 4) hold(p, CPB);
    hold(stop_lvl, CPB);
    hold(1'b1, CPB);
  endtask

  // Monitor: compares every strobe with the head of the queue.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (prev_valid) begin
          checks++;
          if (data_valid) begin
            fails++;
            $display("FAIL R11 strobe width: valid=%b expected 0 in the following cycle", data_valid);
          end
        end
        if (data_valid) begin
          checks++;
          if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R1 unexpected strobe: data=%h expected no strobe", data_out);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (data_out !== e.d || err_start !== e.es || err_parity !== e.ep || err_frame !== e.ef) begin
              fails++;
              $display("FAIL %s: got d=%h s=%b p=%b f=%b expected d=%h s=%b p=%b f=%b",
                       e.tag, data_out, err_start, err_parity, err_frame, e.d, e.es, e.ep, e.ef);
            end
          end
        end else if (err_start || err_parity || err_frame) begin
          checks++;
          fails++;
          $display("FAIL R11 flag without strobe: s=%b p=%b f=%b expected 000",
                   err_start, err_parity, err_frame);
        end
        prev_valid = data_valid;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (data_valid || err_start || err_parity || err_frame) begin
      fails++;
      $display("FAIL R1 reset state: v=%b s=%b p=%b f=%b expected 0000",
               data_valid, err_start, err_parity, err_frame);
    end
    hold(1'b1, 100); // R1: idle line must give no strobe (monitor flags any)

    // d, len, msb, par, chk, inv, bad_par, stop, glitch, flip, tag
    send(9'h0A5, 8, 0, 0, 1, 0, 0, 1, 0, 0, "R2 8-bit lsb A5");
    send(9'h03C, 8, 0, 0, 1, 0, 0, 1, 0, 0, "R2 8-bit lsb 3C");
    send(9'h015, 5, 0, 0, 1, 0, 0, 1, 0, 0, "R3 5-bit");
    send(9'h1A7, 9, 0, 0, 1, 0, 0, 1, 0, 0, "R3 9-bit");
    send(9'h1FF, 7, 0, 0, 1, 0, 0, 1, 0, 0, "R3 7-bit upper cleared");
    send(9'h016, 3, 0, 0, 1, 0, 0, 1, 0, 0, "R3 length clamps to 5");
    send(9'h0C1, 8, 1, 0, 1, 0, 0, 1, 0, 0, "R4 msb-first 8-bit");
    send(9'h12B, 9, 1, 0, 1, 0, 0, 1, 0, 0, "R4 msb-first 9-bit");
    send(9'h013, 6, 1, 0, 1, 0, 0, 1, 0, 0, "R4 msb-first 6-bit");
    send(9'h0B7, 8, 0, 1, 1, 0, 0, 1, 0, 0, "R5 odd ok");
    send(9'h0B7, 8, 0, 1, 1, 0, 1, 1, 0, 0, "R5 odd bad");
    send(9'h055, 8, 0, 2, 1, 0, 0, 1, 0, 0, "R5 even ok");
    send(9'h054, 7, 0, 2, 1, 0, 1, 1, 0, 0, "R5 even bad");
    send(9'h0E2, 8, 0, 3, 1, 0, 0, 1, 0, 0, "R6 space ok");
    send(9'h0E2, 8, 0, 3, 1, 0, 1, 1, 0, 0, "R6 space bad");
    send(9'h019, 5, 0, 4, 1, 0, 0, 1, 0, 0, "R6 mark ok");
    send(9'h019, 5, 0, 4, 1, 0, 1, 1, 0, 0, "R6 mark bad");
    send(9'h0B7, 8, 0, 1, 0, 0, 1, 1, 0, 0, "R7 check off hides error");
    send(9'h0F0, 8, 0, 0, 1, 0, 0, 0, 0, 0, "R7 R8 no slot, stop low");
    send(9'h0F0, 8, 0, 6, 1, 0, 0, 0, 0, 0, "R7 code 6 has no slot");
    send(9'h081, 8, 0, 0, 1, 0, 0, 0, 0, 0, "R8 framing error");
    send(9'h042, 8, 0, 0, 1, 0, 0, 1, 0, 0, "R8 frame after error");
    send(9'h06D, 8, 0, 0, 1, 0, 0, 1, 1, 0, "R9 bad start keeps data");
    send(9'h0A5, 8, 0, 0, 1, 1, 0, 1, 0, 0, "R10 inverted line");
    send(9'h133, 9, 1, 2, 1, 1, 1, 1, 0, 0, "R10 inverted with parity");
    send(9'h0A5, 8, 0, 0, 1, 0, 0, 1, 0, 0, "R10 back to normal");
    send(9'h0C6, 8, 0, 1, 1, 0, 0, 1, 0, 1, "R12 config change mid-frame");
    send(9'h00B, 6, 1, 0, 1, 0, 0, 1, 0, 1, "R12 second mid-frame change");
    send(9'h0C6, 8, 0, 2, 1, 0, 1, 1, 0, 0, "R12 next frame uses new config");

    hold(1'b1, 3 * CPB);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11 missing strobes: %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule